// File: doc/BRIEF.md
# Telephone Pulse Dialing Generator

This block is the loop-disconnect stage of a telephone dialer. A keypad front end hands it decoded digits over a valid/ready stream and raises a single-cycle flash request. The block queues the digits, turns each digit into a train of line breaks and drives two active-high enables: `dp_o`, which opens the line loop through an open-drain pad, and `mute_o`, which silences the handset while dialing or flashing. All timing comes from a millisecond tick that is divided down from the crystal clock. The tick restarts at every phase change, so each phase lasts a whole number of milliseconds.

A two-bit strap input selects the operating mode. It is sampled only when a dialing sequence starts from idle. Tone mode drains the queue without producing pulses. The two pulse modes differ only in their make/break ratio. A hook input resets the whole block while the handset is on-hook.

Digit stream rules: a digit transfers on a rising clock edge when `dig_valid_i` and `dig_ready_o` are both high. `dig_ready_o` is low while the queue holds `QUEUE_DEPTH` digits or while on-hook. A source that sees ready low keeps its digit and valid until a transfer takes place. Codes 10 to 15 are accepted by the handshake and then discarded. The `FAST` parameter halves the pulse period from 100 ms to 50 ms and keeps both ratios.

Top module: `pulse_dialer`

## Requirements
- R1: While `hook_i` is high, one clock edge later `dp_o` and `mute_o` are low, the digit queue and any pending flash are cleared, and `dig_ready_o` is low in the same cycle.
- R2: A digit code N from 1 to 9 produces N breaks, code 0 produces 10 breaks, and codes 10 to 15 are accepted and produce no output.
- R3: With strap code 2'b01, every pulse is a break of 3/5 of the period followed by a make of 2/5 of the period. At the default 100 ms period this is 60 ms and 40 ms, and each millisecond lasts `CLK_PER_MS` clock cycles.
- R4: With strap code 2'b10 or 2'b11, the make lasts one third of the period, rounded down (33 ms), and the break lasts the rest of the period (67 ms).
- R5: With strap code 2'b00 (tone), queued digits are removed and discarded with no break and no mute.
- R6: After the last make of each digit, an 800 ms pause follows with the loop made. Then the next queued digit starts its first break directly.
- R7: `mute_o` is high from the first break of a sequence until the final pause ends, and throughout a flash. `dp_o` is never high without `mute_o`.
- R8: A flash request raises `dp_o` and `mute_o` for 600 ms in every strap mode. It starts two edges after the request when the block is idle. A request made during dialing is served once the current pause has ended. Digits that arrive during a flash are queued.
- R9: Digits are dialed in arrival order from a 16-entry queue. When idle, the first break starts on the edge after the transfer edge. `dig_ready_o` is low whenever the queue is full.
- R10: The ratio is latched when a sequence starts from idle. A strap change during a sequence has no effect until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hook_i | input | 1 | High when the handset is on-hook |
| strap_i | input | 2 | Mode strap: 00 tone, 01 ratio 40:60, 10/11 ratio 33:67 |
| flash_req_i | input | 1 | Single-cycle flash request |
| dig_valid_i | input | 1 | Digit stream valid |
| dig_data_i | input | 4 | Digit code, 0 to 9 dialable |
| dig_ready_o | output | 1 | Digit stream ready |
| dp_o | output | 1 | Line break enable (open-drain pad drive) |
| mute_o | output | 1 | Handset mute enable |

## Verification
The bench compares both outputs cycle by cycle against a timeline that it derives from the period, the ratio and the pause. A design that miscounts digit 0, that rounds the one-third make the wrong way or that drops the output for one cycle between queued digits therefore fails on the exact cycle involved. Further cases cover a strap change in the middle of a digit, which a design that does not latch the mode would dial at the wrong ratio. They also cover tone-mode digits that must vanish rather than appear at a later pulse-mode request, and a flash that arrives during dialing, which must wait for the pause to end and must not cut the digit short. Other sequences hang up in the middle of a digit and must leave nothing queued, and they fill the queue to 16 entries to show back-pressure with no digit lost or reordered.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    STRAP_TONE  = 2'b00,
    STRAP_HIGH  = 2'b01,
    STRAP_FLOAT = 2'b10,
    STRAP_ALT   = 2'b11
  } strap_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_BREAK,
    SQ_MAKE,
    SQ_PAUSE,
    SQ_FLASH
  } seq_state_e;

  function automatic int unsigned period_ms(bit fast);
    return fast ? 50 : 100;
  endfunction

  // third = 1 selects the one-third make, else two-fifths make
  function automatic int unsigned make_ms(bit fast, bit third);
    int unsigned p;
    p = period_ms(fast);
    return third ? (p / 3) : ((p * 2) / 5);
  endfunction

  function automatic int unsigned break_ms(bit fast, bit third);
    return period_ms(fast) - make_ms(fast, third);
  endfunction

  function automatic logic [3:0] pulses_for(logic [3:0] code);
    return (code == 4'd0) ? 4'd10 : code;
  endfunction

endpackage

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int unsigned DIV = 3580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ clr_i;
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clr_i || cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pd_fifo.sv
module pd_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter bit          FAST     = 1'b0,
  parameter int unsigned PAUSE_MS = 800,
  parameter int unsigned FLASH_MS = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hook_i,
  input  logic [1:0] strap_i,
  input  logic       flash_req_i,
  input  logic       tick_i,
  input  logic       q_empty_i,
  input  logic [3:0] q_head_i,
  output logic       pop_o,
  output logic       tick_clr_o,
  output logic       dp_o,
  output logic       mute_o,
  output logic       third_o
);
  localparam int unsigned MK40 = make_ms(FAST, 1'b0);
  localparam int unsigned MK33 = make_ms(FAST, 1'b1);
  localparam int unsigned BK40 = break_ms(FAST, 1'b0);
  localparam int unsigned BK33 = break_ms(FAST, 1'b1);
  localparam int unsigned LONG_A = (PAUSE_MS > FLASH_MS) ? PAUSE_MS : FLASH_MS;
  localparam int unsigned LONGEST = (LONG_A > BK33) ? LONG_A : BK33;
  localparam int unsigned TW = $clog2(LONGEST + 1);

  seq_state_e    st_q, st_d;
  logic [TW-1:0] ms_q, ms_d;
  logic [3:0]    left_q, left_d;
  logic          third_q, third_d;
  logic          pend_q, pend_d;
  logic          pop, load, done;

  function automatic logic [TW-1:0] brk_len(logic third);
    return third ? TW'(BK33 - 1) : TW'(BK40 - 1);
  endfunction

  function automatic logic [TW-1:0] mak_len(logic third);
    return third ? TW'(MK33 - 1) : TW'(MK40 - 1);
  endfunction

  assign done = tick_i && (ms_q == '0);

  always_comb begin
    st_d    = st_q;
    ms_d    = ms_q;
    left_d  = left_q;
    third_d = third_q;
    pend_d  = pend_q | flash_req_i;
    pop     = 1'b0;
    load    = 1'b0;
    if (st_q != SQ_IDLE && tick_i && ms_q != '0) ms_d = ms_q - TW'(1);
    case (st_q)
      SQ_IDLE: begin
        if (pend_q) begin
          st_d   = SQ_FLASH;
          ms_d   = TW'(FLASH_MS - 1);
          load   = 1'b1;
          pend_d = flash_req_i;
        end else if (!q_empty_i) begin
          pop = 1'b1;
          if (strap_e'(strap_i) != STRAP_TONE) begin
            third_d = strap_i[1];
            left_d  = pulses_for(q_head_i);
            st_d    = SQ_BREAK;
            ms_d    = brk_len(strap_i[1]);
            load    = 1'b1;
          end
        end
      end
      SQ_BREAK: begin
        if (done) begin
          st_d = SQ_MAKE;
          ms_d = mak_len(third_q);
          load = 1'b1;
        end
      end
      SQ_MAKE: begin
        if (done) begin
          load = 1'b1;
          if (left_q == 4'd1) begin
            st_d = SQ_PAUSE;
            ms_d = TW'(PAUSE_MS - 1);
          end else begin
            left_d = left_q - 4'd1;
            st_d   = SQ_BREAK;
            ms_d   = brk_len(third_q);
          end
        end
      end
      SQ_PAUSE: begin
        if (done) begin
          load = 1'b1;
          if (!pend_q && !q_empty_i) begin
            pop    = 1'b1;
            left_d = pulses_for(q_head_i);
            st_d   = SQ_BREAK;
            ms_d   = brk_len(third_q);
          end else begin
            st_d = SQ_IDLE;
          end
        end
      end
      SQ_FLASH: begin
        if (done) begin
          st_d = SQ_IDLE;
          load = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hook_i) begin
      st_q    <= SQ_IDLE;
      ms_q    <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      third_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ms_q    <= ms_d;
      left_q  <= left_d;
      pend_q  <= pend_d;
      third_q <= third_d;
    end
  end

  assign pop_o      = pop && !hook_i;
  assign tick_clr_o = load || hook_i;
  assign dp_o       = (st_q == SQ_BREAK) || (st_q == SQ_FLASH);
  assign mute_o     = (st_q != SQ_IDLE);
  assign third_o    = third_q;
endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer #(
  parameter int unsigned CLK_PER_MS  = 3580,
  parameter bit          FAST        = 1'b0,
  parameter int unsigned QUEUE_DEPTH = 16,
  parameter int unsigned PAUSE_MS    = 800,
  parameter int unsigned FLASH_MS    = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hook_i,
  input  logic [1:0] strap_i,
  input  logic       flash_req_i,
  input  logic       dig_valid_i,
  input  logic [3:0] dig_data_i,
  output logic       dig_ready_o,
  output logic       dp_o,
  output logic       mute_o
);
  localparam int unsigned DIG_W = 4;

  logic             tick, tick_clr;
  logic             q_push, q_pop, q_empty, q_full;
  logic [DIG_W-1:0] q_head;
  logic             seq_third;

  assign dig_ready_o = !q_full && !hook_i;
  assign q_push      = dig_valid_i && dig_ready_o && (dig_data_i <= 4'd9);

  pd_tick_gen #(.DIV(CLK_PER_MS)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tick_clr),
    .tick_o (tick)
  );

  pd_fifo #(.DEPTH(QUEUE_DEPTH), .W(DIG_W)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (hook_i),
    .push_i  (q_push),
    .wdata_i (dig_data_i),
    .pop_i   (q_pop),
    .rdata_o (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  pd_seq #(.FAST(FAST), .PAUSE_MS(PAUSE_MS), .FLASH_MS(FLASH_MS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hook_i      (hook_i),
    .strap_i     (strap_i),
    .flash_req_i (flash_req_i),
    .tick_i      (tick),
    .q_empty_i   (q_empty),
    .q_head_i    (q_head),
    .pop_o       (q_pop),
    .tick_clr_o  (tick_clr),
    .dp_o        (dp_o),
    .mute_o      (mute_o),
    .third_o     (seq_third)
  );
endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk
  import pd_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 3580,
  parameter bit          FAST       = 1'b0,
  parameter int unsigned FLASH_MS   = 600
) (
  input logic clk,
  input logic rst_n,
  input logic hook_i,
  input logic ready_i,
  input logic dp_i,
  input logic mute_i,
  input logic full_i,
  input logic third_i
);
  localparam int unsigned RUN40 = break_ms(FAST, 1'b0) * CLK_PER_MS;
  localparam int unsigned RUN33 = break_ms(FAST, 1'b1) * CLK_PER_MS;
  localparam int unsigned RUNFL = FLASH_MS * CLK_PER_MS;

  int unsigned run_q;
  logic        abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 0;
      abort_q <= 1'b0;
    end else begin
      run_q <= dp_i ? run_q + 1 : 0;
      if (hook_i) abort_q <= 1'b1;
      else if (!dp_i) abort_q <= 1'b0;
    end
  end

  a_r1_onhook_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hook_i |=> (!dp_i && !mute_i));

  a_r1_onhook_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    hook_i |-> !ready_i);

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |-> !ready_i);

  a_r7_dp_inside_mute: assert property (@(posedge clk) disable iff (!rst_n)
    dp_i |-> mute_i);

  a_r10_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_i && $past(mute_i)) |-> $stable(third_i));

  // R3, R4, R8: every completed break or flash has one of the legal lengths
  a_r3_break_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_i && run_q != 0 && !abort_q) |->
      (run_q == RUN40 || run_q == RUN33 || run_q == RUNFL));
endmodule

bind pulse_dialer pulse_dialer_chk #(
  .CLK_PER_MS (CLK_PER_MS),
  .FAST       (FAST),
  .FLASH_MS   (FLASH_MS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hook_i  (hook_i),
  .ready_i (dig_ready_o),
  .dp_i    (dp_o),
  .mute_i  (mute_o),
  .full_i  (q_full),
  .third_i (seq_third)
);

// File: tb/pulse_dialer_bench.sv
`timescale 1ns/1ps
module pulse_dialer_bench;
  localparam int T        = 2;
  localparam int PER_MS   = 100;
  localparam int PAUSE_CY = 800 * T;
  localparam int FLASH_CY = 600 * T;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hook = 1'b0;
  logic [1:0] strap = 2'b01;
  logic       flash = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] data = 4'd0;
  logic       ready, dp, mute;

  int n_chk = 0;
  int n_fail = 0;
  int q_dig[$];

  always #5 clk = ~clk;

  pulse_dialer #(.CLK_PER_MS(T)) u_pulse_dialer (
    .clk(clk), .rst_n(rst_n), .hook_i(hook), .strap_i(strap),
    .flash_req_i(flash), .dig_valid_i(valid), .dig_data_i(data),
    .dig_ready_o(ready), .dp_o(dp), .mute_o(mute)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_run(int len, bit edp, bit emu, string req);
    int bad = -1;
    logic adp, amu;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ((dp !== edp || mute !== emu) && bad < 0) begin
        bad = i; adp = dp; amu = mute;
      end
    end
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: run cycle %0d of %0d dp,mute got %b%b expected %b%b",
               req, bad, len, adp, amu, edp, emu);
    end
  endtask

  task automatic expect_digit(int d, bit third, string req);
    int n   = (d == 0) ? 10 : d;
    int mk  = third ? (PER_MS / 3) : (PER_MS * 2 / 5);
    int bk  = PER_MS - mk;
    for (int p = 0; p < n; p++) begin
      expect_run(bk * T, 1'b1, 1'b1, req);
      expect_run(mk * T, 1'b0, 1'b1, req);
    end
    expect_run(PAUSE_CY, 1'b0, 1'b1, "R6");
  endtask

  task automatic run_digits(bit third, string req);
    fork
      begin
        for (int i = 0; i < q_dig.size(); i++) begin
          @(negedge clk); valid = 1'b1; data = 4'(q_dig[i]);
          @(posedge clk);
        end
        @(negedge clk); valid = 1'b0;
        if (q_dig.size() == 17) begin
          valid = 1'b1; data = 4'd9;
          #1 chk(ready == 1'b0, "R9", "ready with 16 queued", ready, 0);
          @(posedge clk);
          @(negedge clk); valid = 1'b0;
        end
      end
      begin
        @(negedge clk); @(posedge clk); @(posedge clk);
        for (int i = 0; i < q_dig.size(); i++) expect_digit(q_dig[i], third, req);
        expect_run(10, 1'b0, 1'b0, "R7");
      end
    join
  endtask

  task automatic push_one(int d);
    @(negedge clk); valid = 1'b1; data = 4'(d);
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic pulse_flash();
    @(negedge clk); flash = 1'b1;
    @(posedge clk);
    @(negedge clk); flash = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(dp == 1'b0, "R7", "dp after reset", dp, 0);
    chk(mute == 1'b0, "R7", "mute after reset", mute, 0);
    chk(ready == 1'b1, "R9", "ready after reset", ready, 1);

    hook = 1'b1; #1;
    chk(ready == 1'b0, "R1", "ready on-hook", ready, 0);
    @(negedge clk); hook = 1'b0;

    // R2 R3 R9: order and counts, including digit 0
    strap = 2'b01;
    q_dig = '{1, 3, 0};
    run_digits(1'b0, "R3");

    // R4: both floating codes use the one-third make
    strap = 2'b10; q_dig = '{2}; run_digits(1'b1, "R4");
    strap = 2'b11; q_dig = '{1}; run_digits(1'b1, "R4");

    // R2: codes above 9 are dropped
    strap = 2'b01;
    push_one(12);
    expect_run(300, 1'b0, 1'b0, "R2");
    chk(ready == 1'b1, "R2", "ready after code 12", ready, 1);

    // R5: tone mode discards; later pulse-mode digit dials alone
    strap = 2'b00;
    push_one(5);
    expect_run(300, 1'b0, 1'b0, "R5");
    strap = 2'b01; q_dig = '{2}; run_digits(1'b0, "R5");

    // R10: strap change during a digit is ignored until idle
    strap = 2'b01; q_dig = '{2};
    fork
      run_digits(1'b0, "R10");
      begin repeat (50) @(negedge clk); strap = 2'b10; end
    join
    q_dig = '{1}; run_digits(1'b1, "R10");

    // R8: flash in tone mode
    strap = 2'b00;
    pulse_flash();
    expect_run(FLASH_CY, 1'b1, 1'b1, "R8");
    expect_run(10, 1'b0, 1'b0, "R8");

    // R8: digit pushed during flash is kept
    strap = 2'b01;
    pulse_flash();
    fork
      begin repeat (100) @(negedge clk); valid = 1'b1; data = 4'd2;
            @(posedge clk); @(negedge clk); valid = 1'b0; end
      begin
        expect_run(FLASH_CY, 1'b1, 1'b1, "R8");
        expect_run(1, 1'b0, 1'b0, "R8");
        expect_digit(2, 1'b0, "R8");
        expect_run(10, 1'b0, 1'b0, "R7");
      end
    join

    // R8: flash requested during a digit waits for the pause to end
    @(negedge clk); valid = 1'b1; data = 4'd1;
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
    @(posedge clk);
    fork
      begin repeat (30) @(negedge clk); flash = 1'b1; @(negedge clk); flash = 1'b0; end
      begin
        expect_digit(1, 1'b0, "R8");
        expect_run(1, 1'b0, 1'b0, "R8");
        expect_run(FLASH_CY, 1'b1, 1'b1, "R8");
        expect_run(10, 1'b0, 1'b0, "R8");
      end
    join

    // R1: hang up in the middle of a digit flushes the queue
    @(negedge clk); valid = 1'b1; data = 4'd3;
    @(posedge clk);
    @(negedge clk); data = 4'd4;
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
    repeat (200) @(negedge clk);
    hook = 1'b1;
    @(negedge clk);
    chk(dp == 1'b0, "R1", "dp after hang-up", dp, 0);
    chk(mute == 1'b0, "R1", "mute after hang-up", mute, 0);
    chk(ready == 1'b0, "R1", "ready while on-hook", ready, 0);
    hook = 1'b0;
    expect_run(400, 1'b0, 1'b0, "R1");
    chk(ready == 1'b1, "R1", "ready after off-hook", ready, 1);

    // R9: fill the queue to 16 and dial all 17 digits in order
    strap = 2'b01;
    q_dig.delete();
    for (int i = 0; i < 17; i++) q_dig.push_back((i % 3) + 1);
    run_digits(1'b0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule